// File: doc/BRIEF.md
# Delay-Locked Loop Bring-Up Sequencer

This block brings a memory PHY's delay-locked loop from reset to a frozen, forced delay with no software involvement. A single start pulse launches a fixed series of writes to two PHY control registers: control register 0 and control register 1. The writes go out through a simple request/acknowledge write port. Each write stays on the port until the receiving side acknowledges it, and only then does the next step begin.

After the loop is switched on and started, the block samples a PHY status word once per clock. It waits for the three lock indication bits to read 1 together. It then takes the coarse lock value from the status word and places it in the force field of control register 0. That value is written back, which pins the delay.

If lock never comes, a programmable poll limit ends the wait with a timeout flag instead of hanging the bring-up.

Top module: `dll_lock_seq`

## Requirements
- R1: After reset, `wr_en`, `done` and `timeout` are all low and no write is issued until `start` is pulsed.
- R2: The first write after `start` targets control register 0 (`wr_sel`=0) with data 0x00101000.
- R3: The second write targets control register 1 (`wr_sel`=1). Its data is the `ctl1_val` sampled in the cycle `start` was accepted; later changes on `ctl1_val` do not affect it.
- R4: The third write is control register 0 with bit 1 added (0x00101002, loop on). The fourth write is control register 0 with bits 1 and 0 added (0x00101003, loop start).
- R5: `wr_en` stays high and `wr_sel`/`wr_data` stay stable until `wr_ack` is seen at a rising clock edge. The next step begins on the cycle after that edge.
- R6: Once the fourth write has been acknowledged, `stat_word` is sampled each cycle. Lock is declared only when `stat_word[2:0]` is 3'b111; any other pattern, including two of the three bits set, keeps polling.
- R7: On lock, a fifth write goes to control register 0 (`wr_sel`=0) with data 0x00101003 OR (`stat_word[13:6]` << 24), using the lock-cycle status. After its acknowledge, `done` goes high and stays high.
- R8: When `poll_limit` consecutive unlocked samples are seen, `timeout` goes high, no force write is issued and no further write follows. A `poll_limit` of 0 disables the limit.
- R9: `start` is ignored while a sequence is in progress. A `start` while `done` or `timeout` is high clears both flags and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to launch the bring-up sequence |
| ctl1_val | input | 32 | Value for control register 1 (refresh count and phase shift) |
| poll_limit | input | PW | Number of unlocked status samples before timeout; 0 waits forever |
| stat_word | input | 32 | PHY status word: lock bits [2:0], coarse lock value [13:6] |
| wr_en | output | 1 | Write request, held until acknowledged |
| wr_sel | output | 1 | Register select: 0 = control register 0, 1 = control register 1 |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge from the PHY register side |
| done | output | 1 | Lock forced, sequence complete |
| timeout | output | 1 | Poll limit reached without lock |

## Verification
The bench builds the block with the default 16-bit poll counter. It drives `poll_limit` with small values such as 6 so that a timeout is reached within a few cycles. It also uses a limit of 0 together with a late lock, which shows that the limit is disabled. Status words that carry two of the three lock bits and a decoy coarse value in [13:6] make a premature lock show up as a wrong force word. Acknowledge delays of zero and several cycles exercise the hold-until-acknowledged behaviour of every write.

// File: rtl/dll_lock_seq.sv
module dll_lock_seq #(
  parameter int          PW        = 16,
  parameter logic [31:0] CTL0_INIT = 32'h0010_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   ctl1_val,
  input  logic [PW-1:0] poll_limit,
  input  logic [31:0]   stat_word,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic          done,
  output logic          timeout
);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_CFG, S_ON, S_RUN, S_POLL, S_FORCE, S_DONE, S_ERR
  } st_t;

  st_t           state;
  logic [31:0]   ctl1_q;
  logic [7:0]    lock_q;
  logic [PW-1:0] cnt;

  wire locked  = &stat_word[2:0];
  wire cnt_hit = ({1'b0, cnt} + 1'b1) == {1'b0, poll_limit};
  wire idle    = (state == S_IDLE) || (state == S_DONE) || (state == S_ERR);

  logic unused_stat;
  assign unused_stat = ^{stat_word[31:14], stat_word[5:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ctl1_q <= '0;
      lock_q <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERR:
          if (start) begin
            state  <= S_INIT;
            ctl1_q <= ctl1_val;
            cnt    <= '0;
          end
        S_INIT:  if (wr_ack) state <= S_CFG;
        S_CFG:   if (wr_ack) state <= S_ON;
        S_ON:    if (wr_ack) state <= S_RUN;
        S_RUN:   if (wr_ack) state <= S_POLL;
        S_POLL:
          if (locked) begin
            lock_q <= stat_word[13:6];
            state  <= S_FORCE;
          end else if (cnt_hit) begin
            state <= S_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_FORCE: if (wr_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_en   = (state inside {S_INIT, S_CFG, S_ON, S_RUN, S_FORCE});
  assign wr_sel  = (state == S_CFG);
  assign done    = (state == S_DONE);
  assign timeout = (state == S_ERR);

  always_comb begin
    case (state)
      S_INIT:  wr_data = CTL0_INIT;
      S_CFG:   wr_data = ctl1_q;
      S_ON:    wr_data = CTL0_INIT | 32'h2;
      S_RUN:   wr_data = CTL0_INIT | 32'h3;
      S_FORCE: wr_data = CTL0_INIT | 32'h3 | {lock_q, 24'h0};
      default: wr_data = '0;
    endcase
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ack) |=> (wr_en && $stable(wr_data) && $stable(wr_sel)));

  p_lock_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FORCE && $past(state) == S_POLL) |-> $past(&stat_word[2:0]));

  p_force_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[31:24] != 8'h00) |-> (wr_data[23:0] == (CTL0_INIT[23:0] | 24'h3)));

  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en && wr_ack && !wr_sel));

  p_err_from_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(state == S_POLL && !(&stat_word[2:0])));

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && state != S_RUN && state != S_POLL && start && !wr_ack) |=> $stable(state));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> !wr_en);

endmodule

// File: tb/dll_lock_seq_tb.sv
module dll_lock_seq_tb;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   ctl1_val = '0;
  logic [PW-1:0] poll_limit = '0;
  logic [31:0]   stat_word = '0;
  logic          wr_en, wr_sel, done, timeout;
  logic [31:0]   wr_data;
  logic          wr_ack = 1'b0;

  int vectors = 0;
  int misses  = 0;
  int ack_dly = 0;
  logic [32:0] exp_q[$];

  always #10 clk = ~clk;

  dll_lock_seq #(.PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl1_val(ctl1_val),
    .poll_limit(poll_limit), .stat_word(stat_word), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .timeout(timeout));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and acknowledges after ack_dly cycles (R2 R3 R4 R5 R7)
  initial forever begin
    @(negedge clk);
    if (wr_en) begin
      logic [32:0] got, exp;
      got = {wr_sel, wr_data};
      if (exp_q.size() == 0) begin
        check("R8 unexpected write", got, 33'h0);
        exp = got;
      end else begin
        exp = exp_q.pop_front();
        check("R2/R3/R4/R7 write word", got, exp);
      end
      for (int i = 0; i < ack_dly; i++) begin
        @(negedge clk);
        check("R5 hold until ack", {wr_en, wr_sel, wr_data}, {1'b1, got});
      end
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
    end
  end

  task automatic run(input logic [31:0] c1, input logic [PW-1:0] lim, input logic [7:0] lv,
                     input int lock_after, input int dly, input bit expect_to);
    logic [31:0] lockw;
    lockw = {18'h2A5A5, lv, 3'b101, 3'b111};
    ack_dly = dly;
    exp_q.push_back({1'b0, 32'h0010_1000});
    exp_q.push_back({1'b1, c1});
    exp_q.push_back({1'b0, 32'h0010_1002});
    exp_q.push_back({1'b0, 32'h0010_1003});
    if (!expect_to) exp_q.push_back({1'b0, 32'h0010_1003 | {lv, 24'h0}});
    stat_word  = {18'h15A5A, ~lv, 3'b010, 3'b011};
    poll_limit = lim;
    ctl1_val   = c1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ctl1_val = ~c1;
    check("R9 flags cleared on restart", {31'h0, done, timeout}, 33'h0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (exp_q.size() > (expect_to ? 0 : 1)) @(negedge clk);
    stat_word = {18'h15A5A, ~lv, 3'b000, 3'b110};
    repeat (lock_after) @(negedge clk);
    if (!expect_to) stat_word = lockw;
    for (int i = 0; i < 2000 && !done && !timeout; i++) @(negedge clk);
    repeat (dly + 3) @(negedge clk);
    stat_word = 32'h0;
    repeat (3) @(negedge clk);
    check(expect_to ? "R8 timeout flag" : "R7 done flag", {31'h0, done, timeout},
          expect_to ? 33'h1 : 33'h2);
    check("R7/R8 all writes seen", 33'(exp_q.size()), 33'h0);
    check("R7/R8 port idle after end", {32'h0, wr_en}, 33'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {30'h0, wr_en, done, timeout}, 33'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 quiet without start", {30'h0, wr_en, done, timeout}, 33'h0);
    run(32'h0000_0085, 16'd20, 8'hC3, 5, 0, 1'b0);
    run(32'h0000_0086, 16'd20, 8'h5A, 0, 3, 1'b0);
    run(32'hDEAD_BE86, 16'd6,  8'h11, 0, 1, 1'b1);
    run(32'h0000_0085, 16'd0,  8'hFF, 60, 2, 1'b0);
    run(32'h1234_5678, 16'd1,  8'h80, 0, 0, 1'b1);
    run(32'h0000_0086, 16'd3,  8'h01, 1, 4, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule